// File: doc/BRIEF.md
# FIFO Address and Fill-Level Controller

This block keeps the bookkeeping for a first-in first-out queue whose entries live in an external memory. It stores no payload. It tracks where the next entry goes and where the oldest entry sits, and counts how many entries are held. A client pulses a one-cycle push strobe or pop strobe, or both at once. The block returns the memory address to use for each, the current fill count, and two flow-control flags.

Each address is a fixed base plus a slot index. The slot index wraps after the last slot, so the depth need not be a power of two. The flags compare the fill count against two thresholds set at build time. Push is allowed while the count is below the push threshold. Pop is allowed while the count is above the pop threshold. With the thresholds set to the depth and to zero, the flags behave as plain not-full and not-empty. Other values reserve headroom or set a minimum batch size.

Top module: `dram_fifo_ptr_ctrl`

## Requirements
- R1: While rst_ni is low and after it rises, level_o is 0 and both wr_addr_o and rd_addr_o equal BASE_ADDR.
- R2: Each clock edge that samples wr_i high moves wr_addr_o to the next slot. The new value is BASE_ADDR plus the previous slot index plus one, and it is visible after that edge.
- R3: The write slot index wraps from DEPTH-1 to 0. With DEPTH 16, 24 pushes leave wr_addr_o at BASE_ADDR + 8.
- R4: Each edge that samples rd_i high moves rd_addr_o to the next slot, with the same wrap from DEPTH-1 to 0.
- R5: A cycle with wr_i high and rd_i low raises level_o by one.
- R6: A cycle with rd_i high and wr_i low lowers level_o by one.
- R7: A cycle with wr_i and rd_i both high leaves level_o unchanged and advances both addresses.
- R8: wr_ok_o is combinational and is 1 exactly when level_o < WR_THRESH.
- R9: rd_ok_o is combinational and is 1 exactly when level_o > RD_THRESH.
- R10: level_o can hold the value DEPTH. After DEPTH pushes with no pops, level_o equals DEPTH and, with WR_THRESH equal to DEPTH, wr_ok_o is 0.
- R11: A cycle with both strobes low changes neither address nor level_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Push strobe, one entry per cycle |
| rd_i | input | 1 | Pop strobe, one entry per cycle |
| wr_addr_o | output | ADDR_W | Memory address for the next push |
| rd_addr_o | output | ADDR_W | Memory address of the oldest entry |
| level_o | output | $clog2(DEPTH+1) | Number of entries held |
| wr_ok_o | output | 1 | Fill count below the push threshold |
| rd_ok_o | output | 1 | Fill count above the pop threshold |

## Verification
The vector table applies the four strobe combinations in turn: push only, pop only, both, and neither. Each combination gives a different pattern of level change and address movement, so a swapped or missing update term shows up as a wrong level or a wrong address. Directed runs then apply long streams of pushes alone, pops alone, and both strobes together. These streams carry each slot index through its wrap, fill the queue to exactly DEPTH, and drain it to empty. They separate a wrong wrap point or a truncated level counter from a correct one, and they toggle both flags at their threshold edges. A nonzero base address shows whether the offset is added to both addresses.

// File: rtl/dfp_pkg.sv
package dfp_pkg;
  typedef enum logic [1:0] {
    LVL_HOLD = 2'd0,
    LVL_INC  = 2'd1,
    LVL_DEC  = 2'd2
  } lvl_op_e;

  function automatic lvl_op_e lvl_op(input logic wr, input logic rd);
    if (wr && !rd) return LVL_INC;
    if (rd && !wr) return LVL_DEC;
    return LVL_HOLD;
  endfunction
endpackage

// File: rtl/dfp_wrap_ctr.sv
module dfp_wrap_ctr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/dfp_level.sv
module dfp_level
  import dfp_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lvl_op_e          op_i,
  output logic [LVL_W-1:0] level_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_o <= '0;
    else begin
      unique case (op_i)
        LVL_INC: level_o <= level_o + 1'b1;
        LVL_DEC: level_o <= level_o - 1'b1;
        default: level_o <= level_o;
      endcase
    end
  end
endmodule

// File: rtl/dfp_flags.sv
module dfp_flags #(
  parameter int unsigned LVL_W     = 5,
  parameter int unsigned WR_THRESH = 16,
  parameter int unsigned RD_THRESH = 0
) (
  input  logic [LVL_W-1:0] level_i,
  output logic             wr_ok_o,
  output logic             rd_ok_o
);
  localparam logic [31:0] WR_T = 32'(WR_THRESH);
  localparam logic [31:0] RD_T = 32'(RD_THRESH);

  logic [31:0] lvl_ext;
  assign lvl_ext = 32'(level_i);
  assign wr_ok_o = lvl_ext < WR_T;
  assign rd_ok_o = lvl_ext > RD_T;
endmodule

// File: rtl/dram_fifo_ptr_ctrl.sv
module dram_fifo_ptr_ctrl
  import dfp_pkg::*;
#(
  parameter int unsigned BASE_ADDR = 0,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned RD_THRESH = 0,
  parameter int unsigned WR_THRESH = 16,
  parameter int unsigned ADDR_W    = 32,
  localparam int unsigned LVL_W    = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              wr_ok_o,
  output logic              rd_ok_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);

  // index 0: write side, index 1: read side
  logic [1:0]             adv;
  logic [PTR_W-1:0]       ptr  [2];
  logic [ADDR_W-1:0]      addr [2];

  assign adv = {rd_i, wr_i};

  for (genvar g = 0; g < 2; g++) begin : g_side
    dfp_wrap_ctr #(.DEPTH(DEPTH)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .adv_i (adv[g]),
      .ptr_o (ptr[g])
    );
    assign addr[g] = BASE_A + ADDR_W'(ptr[g]);
  end

  assign wr_addr_o = addr[0];
  assign rd_addr_o = addr[1];

  dfp_level #(.LVL_W(LVL_W)) u_level (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (lvl_op(wr_i, rd_i)),
    .level_o(level_o)
  );

  dfp_flags #(
    .LVL_W    (LVL_W),
    .WR_THRESH(WR_THRESH),
    .RD_THRESH(RD_THRESH)
  ) u_flags (
    .level_i(level_o),
    .wr_ok_o(wr_ok_o),
    .rd_ok_o(rd_ok_o)
  );
endmodule

// File: rtl/dfp_chk.sv
module dfp_chk #(
  parameter int unsigned BASE_ADDR = 0,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LVL_W     = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic [LVL_W-1:0]  level_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] LAST   = ADDR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0]  FULL   = LVL_W'(DEPTH);

  function automatic logic [ADDR_W-1:0] nxt(input logic [ADDR_W-1:0] off);
    return (off == LAST) ? '0 : off + 1'b1;
  endfunction

  p_wr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (wr_addr_o - BASE_A) == nxt($past(wr_addr_o) - BASE_A));
  p_rd_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (rd_addr_o - BASE_A) == nxt($past(rd_addr_o) - BASE_A));
  p_wr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(wr_addr_o));
  p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_addr_o));
  p_lvl_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i) |=> level_o == $past(level_o) + 1'b1);
  p_lvl_dn_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> level_o == $past(level_o) - 1'b1);
  p_lvl_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i == rd_i) |=> $stable(level_o));
  p_lvl_cap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= FULL);
  p_addr_rng_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_addr_o - BASE_A) <= LAST && (rd_addr_o - BASE_A) <= LAST);
endmodule

bind dram_fifo_ptr_ctrl dfp_chk #(
  .BASE_ADDR(BASE_ADDR),
  .DEPTH    (DEPTH),
  .ADDR_W   (ADDR_W),
  .LVL_W    (LVL_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .wr_addr_o(wr_addr_o),
  .rd_addr_o(rd_addr_o),
  .level_o  (level_o)
);

// File: tb/dram_fifo_ptr_ctrl_test.sv
`timescale 1ns/1ps
module dram_fifo_ptr_ctrl_test;
  localparam int unsigned BASE  = 32'h1000;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr = 1'b0, rd = 1'b0;
  logic [31:0]       wr_addr, rd_addr;
  logic [LVL_W-1:0]  level;
  logic              wr_ok, rd_ok;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dram_fifo_ptr_ctrl #(
    .BASE_ADDR(BASE), .DEPTH(DEPTH), .RD_THRESH(0), .WR_THRESH(DEPTH), .ADDR_W(32)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd),
    .wr_addr_o(wr_addr), .rd_addr_o(rd_addr), .level_o(level),
    .wr_ok_o(wr_ok), .rd_ok_o(rd_ok)
  );

  // {wr, rd, level, write slot, read slot} after the edge
  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [7:0] lvl;
    logic [7:0] wp;
    logic [7:0] rp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'd1, 8'd1, 8'd0},  // R5 R2
    '{1'b1, 1'b0, 8'd2, 8'd2, 8'd0},  // R5
    '{1'b1, 1'b1, 8'd2, 8'd3, 8'd1},  // R7
    '{1'b1, 1'b1, 8'd2, 8'd4, 8'd2},  // R7
    '{1'b0, 1'b1, 8'd1, 8'd4, 8'd3},  // R6 R4
    '{1'b0, 1'b1, 8'd0, 8'd4, 8'd4},  // R6
    '{1'b0, 1'b0, 8'd0, 8'd4, 8'd4},  // R11
    '{1'b1, 1'b0, 8'd1, 8'd5, 8'd4},  // R5
    '{1'b0, 1'b0, 8'd1, 8'd5, 8'd4},  // R11
    '{1'b0, 1'b1, 8'd0, 8'd5, 8'd5}   // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r);
    @(negedge clk);
    wr = w; rd = r;
    @(posedge clk);
    #1;
  endtask

  task automatic check_state(input string req, input int lv, input int wp, input int rp);
    chk(req, 32'(level), 32'(lv));
    chk(req, wr_addr, BASE + 32'(wp));
    chk(req, rd_addr, BASE + 32'(rp));
    chk({req, " R8"}, 32'(wr_ok), 32'(lv < int'(DEPTH)));
    chk({req, " R9"}, 32'(rd_ok), 32'(lv > 0));
  endtask

  task automatic do_reset;
    @(negedge clk);
    wr = 0; rd = 0; rst_n = 0;
    #1;
    check_state("R1 in reset", 0, 0, 0);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    #1;
    check_state("R1 after reset", 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].rd);
      check_state($sformatf("R2 R4 R5 R6 R7 R11 vec%0d", i),
                  int'(VECS[i].lvl), int'(VECS[i].wp), int'(VECS[i].rp));
    end

    // fill to DEPTH from level 0 at slot 5; slot index passes 15 -> 0 at push 11
    for (int k = 1; k <= int'(DEPTH); k++) begin
      step(1'b1, 1'b0);
      if (k == 11) check_state("R3 wrap", 11, 0, 5);
    end
    check_state("R10 full", int'(DEPTH), 5, 5);
    chk("R10 wr_ok low", 32'(wr_ok), 32'd0);

    // drain to empty; read slot wraps too
    for (int k = 1; k <= int'(DEPTH); k++) begin
      step(1'b0, 1'b1);
      if (k == 11) check_state("R4 wrap", int'(DEPTH) - 11, 5, 0);
    end
    check_state("R9 empty", 0, 5, 5);
    chk("R9 rd_ok low", 32'(rd_ok), 32'd0);

    // 8 pushes then 16 push+pop: 24 pushes total
    do_reset();
    for (int k = 0; k < 8; k++) step(1'b1, 1'b0);
    for (int k = 0; k < 16; k++) step(1'b1, 1'b1);
    check_state("R3 R7 24 pushes", 8, 8, 0);

    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check_state("R11 idle hold", 8, 8, 0);

    // mid-run reset
    do_reset();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule